// File: doc/BRIEF.md
# Packed Payload Unpacker and Write Address Sequencer

This block executes the data phase of a block-write command. It is given a start address, a number of 32-bit payload words and a 2-bit packing format. It then takes the payload words one at a time from an upstream stream. Each word is cut into one, two, three or four sub-values. Every sub-value becomes its own write to a downstream target, and each write goes to the address after the previous one. When the last sub-value of the last payload word has been acknowledged, the block raises a one-cycle completion pulse.

The payload input is a valid/ready stream. A word transfers on a clock edge where `pl_valid` and `pl_ready` are both high. `pl_ready` is high only while no sub-value of the previous word is still waiting to be written, so upstream back-pressure comes entirely from the write side. Upstream may change `pl_data` freely while `pl_ready` is low. The write output is a request/acknowledge pair. Once `tw_req` is raised, it stays high with a stable address and data until the edge on which `tw_ack` is sampled high. The target can stall for any number of cycles. A command is launched with a one-cycle `go` pulse. The command inputs are sampled only while the block is idle.

Top module: `pkd_unpack_top`

## Requirements
- R1: Immediately after reset, `pl_ready`, `tw_req` and `fin` are all low.
- R2: Format code 0 (raw) produces exactly one write per payload word, and the write data is the whole 32-bit word.
- R3: Format code 1 (halves) produces two writes per payload word: bits 15..0 first, then bits 31..16, each zero-extended.
- R4: Format code 2 (ten-bit) produces three writes per payload word: bits 9..0, then 19..10, then 29..20, each zero-extended. Bits 31..30 never reach `tw_data`.
- R5: Format code 3 (bytes) produces four writes per payload word, from bits 7..0 up to bits 31..24, each zero-extended.
- R6: The first write goes to `go_addr`, and the address rises by one (modulo 2^ADDR_W) after every acknowledged write. `go_count` counts payload words, not sub-values, so three ten-bit words starting at 0x7000 end with a write to 0x7008.
- R7: Once `tw_req` is raised, it stays high with `tw_addr` and `tw_data` unchanged until `tw_ack` is sampled high.
- R8: `pl_ready` is high only when every sub-value of the previous word has been acknowledged and payload words remain. It is never high together with `tw_req`.
- R9: `fin` is a single-cycle pulse in the cycle right after the final acknowledged write.
- R10: A `go` with `go_count` = 0 produces `fin` in the next cycle, with no write and no payload acceptance.
- R11: A `go` pulse that arrives while a command is in progress is ignored and does not change the writes that are issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| go | input | 1 | Launch pulse, sampled only when idle |
| go_addr | input | ADDR_W | First target address |
| go_count | input | CNT_W | Number of payload words |
| go_fmt | input | 2 | Packing format code (0 raw, 1 halves, 2 ten-bit, 3 bytes) |
| pl_valid | input | 1 | Payload word offered |
| pl_data | input | 32 | Payload word |
| pl_ready | output | 1 | Block can take a payload word |
| tw_req | output | 1 | Target write requested |
| tw_addr | output | ADDR_W | Target write address |
| tw_data | output | DATA_W | Target write data, zero-extended |
| tw_ack | input | 1 | Target accepted the write |
| fin | output | 1 | Command complete pulse |

## Verification
Each format is driven with words whose sub-fields all differ and whose upper bits are set. A wrong slice position, a wrong order or a missing zero-extension therefore shows up as a data mismatch, and in ten-bit mode the set bits 31..30 would reveal any leak. The tests run first with a target that always acknowledges and an upstream that is always valid, and then with random stalls on both sides. This separates errors in the handshake and hold logic from errors in the slicing. Dedicated cases cover an address that wraps at the top of the space, a zero count, a three-word ten-bit run from 0x7000 that must end at 0x7008, and stray launch pulses during a busy command.

// File: rtl/pkd_unpack_pkg.sv
package pkd_unpack_pkg;
  typedef enum logic [1:0] {
    FMT_RAW  = 2'd0,
    FMT_HALF = 2'd1,
    FMT_TEN  = 2'd2,
    FMT_BYTE = 2'd3
  } pack_fmt_e;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_FETCH = 2'd1,
    PH_WRITE = 2'd2
  } phase_e;

  localparam int unsigned WORD_W = 32;

  // index of the final sub-value of a word for a given format
  function automatic logic [1:0] final_slot(pack_fmt_e f);
    case (f)
      FMT_RAW:  return 2'd0;
      FMT_HALF: return 2'd1;
      FMT_TEN:  return 2'd2;
      default:  return 2'd3;
    endcase
  endfunction
endpackage

// File: rtl/pkd_slicer.sv
module pkd_slicer
  import pkd_unpack_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic [WORD_W-1:0] word,
  input  pack_fmt_e         fmt,
  input  logic [1:0]        slot,
  output logic [DATA_W-1:0] value
);
  localparam int unsigned N_BYTE = 4;
  localparam int unsigned N_TEN  = 3;
  localparam int unsigned N_HALF = 2;

  logic [7:0]  byte_lane [N_BYTE];
  logic [9:0]  ten_lane  [N_TEN];
  logic [15:0] half_lane [N_HALF];

  for (genvar g = 0; g < N_BYTE; g++) begin : g_byte
    assign byte_lane[g] = word[g*8 +: 8];
  end
  for (genvar g = 0; g < N_TEN; g++) begin : g_ten
    assign ten_lane[g] = word[g*10 +: 10];
  end
  for (genvar g = 0; g < N_HALF; g++) begin : g_half
    assign half_lane[g] = word[g*16 +: 16];
  end

  always_comb begin
    value = '0;
    case (fmt)
      FMT_RAW:  value[WORD_W-1:0] = word;
      FMT_HALF: value[15:0] = half_lane[slot[0]];
      FMT_TEN:  value[9:0]  = (slot == 2'd0) ? ten_lane[0] :
                              (slot == 2'd1) ? ten_lane[1] : ten_lane[2];
      default:  value[7:0]  = byte_lane[slot];
    endcase
  end
endmodule

// File: rtl/pkd_addr_seq.sv
module pkd_addr_seq #(
  parameter int unsigned ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] base,
  input  logic              advance,
  output logic [ADDR_W-1:0] addr
);
  always_ff @(posedge clk) begin
    if (!rst_n)       addr <= '0;
    else if (load)    addr <= base;
    else if (advance) addr <= addr + 1'b1;
  end
endmodule

// File: rtl/pkd_ctrl.sv
module pkd_ctrl
  import pkd_unpack_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go,
  input  logic [CNT_W-1:0]  go_count,
  input  logic [1:0]        go_fmt,
  input  logic              pl_valid,
  input  logic [WORD_W-1:0] pl_data,
  output logic              pl_ready,
  output logic              tw_req,
  input  logic              tw_ack,
  output logic              addr_load,
  output logic              addr_step,
  output logic [WORD_W-1:0] word_q,
  output pack_fmt_e         fmt_q,
  output logic [1:0]        slot_q,
  output logic              fin
);
  phase_e           phase;
  logic [CNT_W-1:0] left_q;
  logic             last_slot;

  assign pl_ready  = (phase == PH_FETCH);
  assign tw_req    = (phase == PH_WRITE);
  assign addr_load = (phase == PH_IDLE) && go;
  assign addr_step = tw_req && tw_ack;
  assign last_slot = (slot_q == final_slot(fmt_q));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase  <= PH_IDLE;
      left_q <= '0;
      word_q <= '0;
      fmt_q  <= FMT_RAW;
      slot_q <= '0;
      fin    <= 1'b0;
    end else begin
      fin <= 1'b0;
      case (phase)
        PH_IDLE: if (go) begin
          fmt_q  <= pack_fmt_e'(go_fmt);
          left_q <= go_count;
          if (go_count == '0) fin   <= 1'b1;
          else                phase <= PH_FETCH;
        end
        PH_FETCH: if (pl_valid) begin
          word_q <= pl_data;
          slot_q <= '0;
          phase  <= PH_WRITE;
        end
        PH_WRITE: if (tw_ack) begin
          if (last_slot) begin
            left_q <= left_q - 1'b1;
            if (left_q == CNT_W'(1)) begin
              fin   <= 1'b1;
              phase <= PH_IDLE;
            end else begin
              phase <= PH_FETCH;
            end
          end else begin
            slot_q <= slot_q + 1'b1;
          end
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pkd_unpack_top.sv
module pkd_unpack_top
  import pkd_unpack_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go,
  input  logic [ADDR_W-1:0] go_addr,
  input  logic [CNT_W-1:0]  go_count,
  input  logic [1:0]        go_fmt,
  input  logic              pl_valid,
  input  logic [31:0]       pl_data,
  output logic              pl_ready,
  output logic              tw_req,
  output logic [ADDR_W-1:0] tw_addr,
  output logic [DATA_W-1:0] tw_data,
  input  logic              tw_ack,
  output logic              fin
);
  logic              addr_load, addr_step;
  logic [WORD_W-1:0] word_q;
  pack_fmt_e         fmt_q;
  logic [1:0]        slot_q;

  pkd_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .go(go), .go_count(go_count), .go_fmt(go_fmt),
    .pl_valid(pl_valid), .pl_data(pl_data), .pl_ready(pl_ready),
    .tw_req(tw_req), .tw_ack(tw_ack), .addr_load(addr_load),
    .addr_step(addr_step), .word_q(word_q), .fmt_q(fmt_q),
    .slot_q(slot_q), .fin(fin)
  );

  pkd_addr_seq #(.ADDR_W(ADDR_W)) u_addr (
    .clk(clk), .rst_n(rst_n), .load(addr_load), .base(go_addr),
    .advance(addr_step), .addr(tw_addr)
  );

  pkd_slicer #(.DATA_W(DATA_W)) u_slice (
    .word(word_q), .fmt(fmt_q), .slot(slot_q), .value(tw_data)
  );
endmodule

// File: rtl/pkd_unpack_chk.sv
module pkd_unpack_chk #(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              pl_ready,
  input logic              tw_req,
  input logic [ADDR_W-1:0] tw_addr,
  input logic [DATA_W-1:0] tw_data,
  input logic              tw_ack,
  input logic              fin
);
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (tw_req && !tw_ack) |=> (tw_req && $stable(tw_addr) && $stable(tw_data))); // R7
  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (tw_req && tw_ack) |=> (!tw_req || tw_addr == $past(tw_addr) + 1'b1)); // R6
  AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
    !(pl_ready && tw_req)); // R8
  AST_FIN_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    fin |=> !fin); // R9
  AST_FIN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    fin |-> (!tw_req && !pl_ready)); // R10
endmodule

bind pkd_unpack_top pkd_unpack_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .pl_ready(pl_ready), .tw_req(tw_req),
  .tw_addr(tw_addr), .tw_data(tw_data), .tw_ack(tw_ack), .fin(fin)
);

// File: tb/sim_pkd_unpack_top.sv
`timescale 1ns/1ps
module sim_pkd_unpack_top;
  localparam int AW = 16;
  localparam int DW = 32;
  localparam int CW = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic go = 1'b0;
  logic [AW-1:0] go_addr = '0;
  logic [CW-1:0] go_count = '0;
  logic [1:0] go_fmt = '0;
  logic pl_valid = 1'b0;
  logic [31:0] pl_data = '0;
  logic pl_ready, tw_req, fin;
  logic [AW-1:0] tw_addr;
  logic [DW-1:0] tw_data;
  logic tw_ack = 1'b0;

  always #5 clk = ~clk;

  pkd_unpack_top #(.ADDR_W(AW), .DATA_W(DW), .CNT_W(CW)) u0 (
    .clk(clk), .rst_n(rst_n), .go(go), .go_addr(go_addr), .go_count(go_count),
    .go_fmt(go_fmt), .pl_valid(pl_valid), .pl_data(pl_data), .pl_ready(pl_ready),
    .tw_req(tw_req), .tw_addr(tw_addr), .tw_data(tw_data), .tw_ack(tw_ack), .fin(fin)
  );

  int checks = 0;
  int errors = 0;
  bit reported = 0;

  // reference model state
  logic [31:0] pq[$];
  bit m_active = 0;
  int m_left = 0;
  int m_pend = 0;
  int m_slot = 0;
  int m_fmt = 0;
  logic [31:0] m_word = '0;
  logic [AW-1:0] m_addr = '0;
  logic [AW-1:0] m_last_addr = '0;
  bit m_fin = 0;
  int m_writes = 0;
  int vprob = 100;
  int aprob = 100;

  function automatic logic [DW-1:0] model_data(logic [31:0] w, int f, int s);
    int width;
    logic [31:0] mask;
    width = (f == 0) ? 32 : (f == 1) ? 16 : (f == 2) ? 10 : 8;
    mask = (f == 0) ? 32'hFFFF_FFFF : ((32'd1 << width) - 1);
    return DW'((w >> (s * width)) & mask);
  endfunction

  function automatic string fmt_tag(int f);
    return (f == 0) ? "R2" : (f == 1) ? "R3" : (f == 2) ? "R4" : "R5";
  endfunction

  task automatic check(bit ok, string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic step(bit st, int f, logic [AW-1:0] a, int cnt);
    bit exp_ready, exp_req;
    @(negedge clk);
    exp_ready = m_active && m_pend == 0 && m_left > 0;
    exp_req = m_pend > 0;
    check(pl_ready == exp_ready, "R8 pl_ready", pl_ready, exp_ready);
    check(tw_req == exp_req, "R7 tw_req", tw_req, exp_req);
    if (exp_req) begin
      check(tw_addr == m_addr, "R6 tw_addr", tw_addr, m_addr);
      check(tw_data == model_data(m_word, m_fmt, m_slot), fmt_tag(m_fmt),
            tw_data, model_data(m_word, m_fmt, m_slot));
    end
    check(fin == m_fin, "R9 R10 fin", fin, m_fin);
    // drive inputs for the next edge
    go = st; go_fmt = f[1:0]; go_addr = a; go_count = CW'(cnt);
    pl_valid = (pq.size() > 0) && (($urandom % 100) < vprob);
    pl_data = (pq.size() > 0) ? pq[0] : $urandom;
    tw_ack = (($urandom % 100) < aprob);
    // advance model across the edge
    m_fin = 0;
    if (!m_active) begin
      if (st) begin
        if (cnt == 0) m_fin = 1;
        else begin
          m_active = 1; m_left = cnt; m_addr = a; m_fmt = f; m_pend = 0;
        end
      end
    end else if (exp_ready && pl_valid) begin
      m_word = pq.pop_front(); m_slot = 0; m_pend = m_fmt + 1;
    end else if (exp_req && tw_ack) begin
      m_last_addr = m_addr; m_addr = m_addr + 1'b1; m_writes++;
      m_slot++; m_pend--;
      if (m_pend == 0) begin
        m_left--;
        if (m_left == 0) begin m_active = 0; m_fin = 1; end
      end
    end
  endtask

  task automatic run_job(int f, logic [AW-1:0] a, int cnt, bit noisy);
    int guard = 0;
    step(1, f, a, cnt);
    while (m_active && guard < 3000) begin
      if (noisy && ($urandom % 4 == 0)) step(1, 3 - f, a + 16'h0100, 1);
      else step(0, 0, '0, 0);
      guard++;
    end
    if (guard >= 3000) check(0, "watchdog", guard, 0);
    step(0, 0, '0, 0);
  endtask

  initial begin
    int w0;
    repeat (3) @(negedge clk);
    check(pl_ready == 0 && tw_req == 0 && fin == 0, "R1 reset outputs",
          {pl_ready, tw_req, fin}, 0);
    rst_n = 1'b1;
    step(0, 0, '0, 0);
    check(pl_ready == 0 && tw_req == 0 && fin == 0, "R1 after release",
          {pl_ready, tw_req, fin}, 0);

    // R2: raw words, no stalls
    pq = '{32'hDEAD_BEEF, 32'h0123_4567, 32'hFFFF_0001};
    run_job(0, 16'h0100, 3, 0);
    check(m_writes == 3, "R2 write count", m_writes, 3);

    // R3: halves with random stalls
    vprob = 60; aprob = 50;
    w0 = m_writes;
    pq = '{32'hAFFE_D00F, 32'h8765_4321};
    run_job(1, 16'h2000, 2, 0);
    check(m_writes - w0 == 4, "R3 write count", m_writes - w0, 4);

    // R4 and R6: three ten-bit words from 0x7000, top bits set
    w0 = m_writes;
    pq = '{32'hEA99_5566, 32'hDEAD_BEEF, 32'hC102_0202};
    run_job(2, 16'h7000, 3, 0);
    check(m_writes - w0 == 9, "R4 write count", m_writes - w0, 9);
    check(m_last_addr == 16'h7008, "R6 final address", m_last_addr, 16'h7008);

    // R5 with address wrap
    w0 = m_writes;
    pq = '{32'h89AB_CDEF, 32'hF00D_CAFE};
    run_job(3, 16'hFFFE, 2, 0);
    check(m_writes - w0 == 8, "R5 write count", m_writes - w0, 8);
    check(m_last_addr == 16'h0005, "R6 wrapped address", m_last_addr, 16'h0005);

    // R10: zero count
    w0 = m_writes;
    pq = '{32'h1111_2222};
    run_job(2, 16'h4000, 0, 0);
    repeat (3) step(0, 0, '0, 0);
    check(m_writes == w0 && pq.size() == 1, "R10 nothing consumed", pq.size(), 1);
    pq.delete();

    // R11: stray launches during a busy command
    w0 = m_writes;
    pq = '{32'h1357_9BDF, 32'h2468_ACE0, 32'h0F0F_F0F0};
    run_job(1, 16'h3000, 3, 1);
    check(m_writes - w0 == 6, "R11 write count", m_writes - w0, 6);
    check(m_last_addr == 16'h3005, "R11 final address", m_last_addr, 16'h3005);

    // long mixed run, all formats back to back
    vprob = 40; aprob = 30;
    for (int f = 0; f < 4; f++) begin
      for (int k = 0; k < 5; k++) pq.push_back($urandom);
      run_job(f, AW'(16'h5000 + f * 32), 5, 1);
    end

    if (!reported) begin
      reported = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
    end
    $finish;
  end

  initial begin
    #1_500_000;
    if (!reported) begin
      reported = 1;
      checks++; errors++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
    end
    $finish;
  end
endmodule